// File: doc/BRIEF.md
# Operand Address-Mode Fetch Sequencer

This block sits between instruction decode and the ALU of a 16-bit minicomputer-style core. For one operand, it turns a 3-bit addressing mode and a register number into the effective address. It then fetches the operand, stores a result there, or stops at the address. The caller chooses which of these three flows to run. The block walks a dedicated path of states for each mode. It talks to word memory through a request line that is held until the memory acknowledges. The acknowledge may carry an error flag.

Autoincrement, autodecrement and index modes change a register: the named register or the program counter. That change is held inside the block and is written to the register file in the single cycle in which the block reports completion. An access that ends in error therefore leaves every register as it was. Byte-lane selection and sign extension are left to the datapath; the block returns the full memory word.

Top module: `ofs_operand_seq`

## Requirements
- R1: After reset, and whenever `busy` is low, `mem_req`, `rf_we`, `done` and `fault` are all low.
- R2: Mode 0 (register) makes no memory access. A read flow returns Rn on `operand`. A write flow writes `wr_data` into Rn. An address-only flow ends in `fault`. In all three, `ea` reads 0.
- R3: Mode 1 (register deferred) uses Rn as the effective address and leaves Rn unchanged.
- R4: Modes 2 and 3 (autoincrement, plain and deferred) make their first access at Rn. On success Rn becomes Rn plus the step. In mode 3 that first access is a word read, and the word it returns is the effective address.
- R5: Modes 4 and 5 (autodecrement, plain and deferred) first form Rn minus the step. That value is the first access address and the new Rn. In mode 5 that access is a word read, and the word it returns is the effective address.
- R6: Modes 6 and 7 (index, plain and deferred) first read an offset word at the program counter (R7). R7 becomes R7+2. The sum is offset + Rn, where Rn = R7 uses the already-incremented value. Mode 6 uses the sum as the effective address; mode 7 reads a word at the sum and uses that word.
- R7: The step is 1 only for a byte operation in mode 2 or 4 on R0..R5. It is 2 in every other case, including the deferred modes and R6/R7.
- R8: The caller selects the flow with `kind`: 0 read, 1 write, 2 address-only (3 behaves as read). A read flow ends with one read at the effective address, returned on `operand`. A write flow ends with one write of `wr_data` there. An address-only flow makes no access at the effective address. Only the final access carries `mem_byte`, which equals `byte_op`.
- R9: Every request keeps `mem_addr`, `mem_we` and `mem_wdata` stable from the cycle `mem_req` rises until the cycle `mem_ack` is high. Any number of wait cycles is allowed.
- R10: An acknowledge with `mem_err` high ends the sequence with `fault` in the next cycle. No further access is made and no register is written.
- R11: Each start yields exactly one one-cycle pulse, either on `done` or on `fault`. The register update, when there is one, is written in the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence; sampled only while idle |
| mode | input | 3 | Addressing mode 0..7 |
| reg_sel | input | 3 | Register number Rn |
| kind | input | 2 | Flow: 0 read, 1 write, 2 address-only |
| byte_op | input | 1 | Byte-sized operand |
| wr_data | input | 16 | Data for write flow |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse on success |
| fault | output | 1 | One-cycle pulse on memory error or illegal mode |
| operand | output | 16 | Operand word of the last read flow |
| ea | output | 16 | Effective address of the last sequence |
| rf_raddr | output | 3 | Register file read address |
| rf_rdata | input | 16 | Register file read data, same cycle |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 3 | Register file write address |
| rf_wdata | output | 16 | Register file write data |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | Request is a write |
| mem_byte | output | 1 | Final operand access is byte-sized |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Access failed, valid with acknowledge |

## Verification
The number of cycles until `done` or `fault` depends on the mode and on the random memory waits. The bench therefore polls at each falling edge for the first of the two pulses. It reads `operand` and `ea` in that same cycle, which is the FIN or ERR state. The register write takes effect at the rising edge that ends the `done` cycle, so the register file is compared one falling edge later. In that same cycle the bench confirms that no second pulse follows. Memory accesses are logged at the edge where the acknowledge is raised. The log is compared with the access list the bench model predicts, truncated after an injected error.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

    localparam int unsigned MODE_W = 3;
    localparam int unsigned KIND_W = 2;

    typedef enum logic [KIND_W-1:0] {
        K_READ  = 2'd0,
        K_WRITE = 2'd1,
        K_ADDR  = 2'd2,
        K_SPARE = 2'd3
    } kind_e;

    typedef enum logic [MODE_W-1:0] {
        M_REG   = 3'd0,
        M_RDEF  = 3'd1,
        M_AINC  = 3'd2,
        M_AINCD = 3'd3,
        M_ADEC  = 3'd4,
        M_ADECD = 3'd5,
        M_IDX   = 3'd6,
        M_IDXD  = 3'd7
    } mode_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DISP,
        S_DEC,
        S_PCRD,
        S_OFS_W,
        S_PTR_W,
        S_EA,
        S_DAT_W,
        S_WR_W,
        S_FIN,
        S_ERR
    } st_e;

    typedef struct packed {
        mode_e mode;
        kind_e kind;
        logic  byte_op;
    } cmd_t;

    // deferred forms always step a pointer word
    function automatic logic is_deferred(mode_e m);
        return m[0];
    endfunction

endpackage

// File: rtl/ofs_step_calc.sv
module ofs_step_calc
    import ofs_pkg::*;
#(
    parameter int unsigned DW     = 16,
    parameter int unsigned RW     = 3,
    parameter int unsigned SP_IDX = 6,
    parameter int unsigned PC_IDX = 7
) (
    input  logic [DW-1:0] base,
    input  logic [RW-1:0] rsel,
    input  mode_e         mode,
    input  logic          byte_op,
    output logic [DW-1:0] inc_val,
    output logic [DW-1:0] dec_val
);
    localparam logic [DW-1:0] WORD_STEP = DW'(2);
    localparam logic [DW-1:0] BYTE_STEP = DW'(1);

    logic          pinned;
    logic [DW-1:0] step;

    assign pinned  = (rsel == RW'(SP_IDX)) || (rsel == RW'(PC_IDX));
    assign step    = (byte_op && !is_deferred(mode) && !pinned) ? BYTE_STEP : WORD_STEP;
    assign inc_val = base + step;
    assign dec_val = base - step;

endmodule

// File: rtl/ofs_memport.sv
module ofs_memport #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [DW-1:0] go_addr,
    input  logic          go_we,
    input  logic          go_byte,
    input  logic [DW-1:0] go_wdata,
    input  logic          mem_ack,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_byte,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_byte  <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else if (go) begin
            mem_req   <= 1'b1;
            mem_we    <= go_we;
            mem_byte  <= go_byte;
            mem_addr  <= go_addr;
            mem_wdata <= go_wdata;
        end else if (mem_req && mem_ack) begin
            mem_req <= 1'b0;
        end
    end

    // R9: request attributes frozen while waiting
    p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata) && $stable(mem_byte)));

endmodule

// File: rtl/ofs_ctrl.sv
module ofs_ctrl
    import ofs_pkg::*;
#(
    parameter int unsigned DW     = 16,
    parameter int unsigned RW     = 3,
    parameter int unsigned PC_IDX = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  mode_e         mode_i,
    input  logic [RW-1:0] reg_sel,
    input  kind_e         kind_i,
    input  logic          byte_op,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] rf_rdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    input  logic          mem_err,
    input  logic [DW-1:0] inc_val,
    input  logic [DW-1:0] dec_val,
    output logic [DW-1:0] base_q,
    output logic [RW-1:0] rsel_q,
    output cmd_t          cmd_q,
    output logic [RW-1:0] rf_raddr,
    output logic          go,
    output logic [DW-1:0] go_addr,
    output logic          go_we,
    output logic          go_byte,
    output logic [DW-1:0] go_wdata,
    output logic          busy,
    output logic          done,
    output logic          fault,
    output logic          rf_we,
    output logic [RW-1:0] rf_waddr,
    output logic [DW-1:0] rf_wdata,
    output logic [DW-1:0] operand,
    output logic [DW-1:0] ea
);
    localparam logic [RW-1:0] PC_SEL    = RW'(PC_IDX);
    localparam logic [DW-1:0] PC_STRIDE = DW'(2);

    st_e           st, st_n;
    logic [DW-1:0] wdat_q, ea_q, opnd_q, wb_val;
    logic [RW-1:0] wb_addr;
    logic          wb_en;
    logic [DW-1:0] idx_base, idx_sum;
    logic          ack_ok, ack_bad;

    assign ack_ok   = mem_ack && !mem_err;
    assign ack_bad  = mem_ack && mem_err;
    assign idx_base = (rsel_q == PC_SEL) ? wb_val : base_q;
    assign idx_sum  = mem_rdata + idx_base;

    always_comb begin
        st_n     = st;
        go       = 1'b0;
        go_addr  = ea_q;
        go_we    = 1'b0;
        go_byte  = 1'b0;
        go_wdata = wdat_q;
        rf_raddr = (st == S_PCRD) ? PC_SEL : reg_sel;
        case (st)
            S_IDLE: if (start) st_n = S_DISP;
            S_DISP: begin
                case (cmd_q.mode)
                    M_REG:          st_n = (cmd_q.kind == K_ADDR) ? S_ERR : S_FIN;
                    M_RDEF, M_AINC: st_n = S_EA;
                    M_AINCD: begin
                        go      = 1'b1;
                        go_addr = base_q;
                        st_n    = S_PTR_W;
                    end
                    M_ADEC, M_ADECD: st_n = S_DEC;
                    default:         st_n = S_PCRD;
                endcase
            end
            S_DEC: begin
                if (cmd_q.mode == M_ADECD) begin
                    go      = 1'b1;
                    go_addr = dec_val;
                    st_n    = S_PTR_W;
                end else begin
                    st_n = S_EA;
                end
            end
            S_PCRD: begin
                go      = 1'b1;
                go_addr = rf_rdata;
                st_n    = S_OFS_W;
            end
            S_OFS_W: begin
                if (ack_bad) begin
                    st_n = S_ERR;
                end else if (ack_ok) begin
                    if (cmd_q.mode == M_IDXD) begin
                        go      = 1'b1;
                        go_addr = idx_sum;
                        st_n    = S_PTR_W;
                    end else begin
                        st_n = S_EA;
                    end
                end
            end
            S_PTR_W: begin
                if (ack_bad)     st_n = S_ERR;
                else if (ack_ok) st_n = S_EA;
            end
            S_EA: begin
                case (cmd_q.kind)
                    K_WRITE: begin
                        go      = 1'b1;
                        go_we   = 1'b1;
                        go_byte = cmd_q.byte_op;
                        st_n    = S_WR_W;
                    end
                    K_ADDR: st_n = S_FIN;
                    default: begin
                        go      = 1'b1;
                        go_byte = cmd_q.byte_op;
                        st_n    = S_DAT_W;
                    end
                endcase
            end
            S_DAT_W, S_WR_W: begin
                if (ack_bad)     st_n = S_ERR;
                else if (ack_ok) st_n = S_FIN;
            end
            default: st_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            cmd_q   <= '0;
            rsel_q  <= '0;
            base_q  <= '0;
            wdat_q  <= '0;
            ea_q    <= '0;
            opnd_q  <= '0;
            wb_en   <= 1'b0;
            wb_addr <= '0;
            wb_val  <= '0;
        end else begin
            st <= st_n;
            case (st)
                S_IDLE: begin
                    if (start) begin
                        cmd_q  <= '{mode: mode_i, kind: kind_i, byte_op: byte_op};
                        rsel_q <= reg_sel;
                        base_q <= rf_rdata;
                        wdat_q <= wr_data;
                        wb_en  <= 1'b0;
                    end
                end
                S_DISP: begin
                    case (cmd_q.mode)
                        M_REG: begin
                            ea_q <= '0;
                            if (cmd_q.kind == K_WRITE) begin
                                wb_en   <= 1'b1;
                                wb_addr <= rsel_q;
                                wb_val  <= wdat_q;
                            end else begin
                                opnd_q <= base_q;
                            end
                        end
                        M_RDEF: ea_q <= base_q;
                        M_AINC, M_AINCD: begin
                            ea_q    <= base_q;
                            wb_en   <= 1'b1;
                            wb_addr <= rsel_q;
                            wb_val  <= inc_val;
                        end
                        default: ;
                    endcase
                end
                S_DEC: begin
                    ea_q    <= dec_val;
                    wb_en   <= 1'b1;
                    wb_addr <= rsel_q;
                    wb_val  <= dec_val;
                end
                S_PCRD: begin
                    wb_en   <= 1'b1;
                    wb_addr <= PC_SEL;
                    wb_val  <= rf_rdata + PC_STRIDE;
                end
                S_OFS_W: if (ack_ok) ea_q <= idx_sum;
                S_PTR_W: if (ack_ok) ea_q <= mem_rdata;
                S_DAT_W: if (ack_ok) opnd_q <= mem_rdata;
                default: ;
            endcase
        end
    end

    assign busy     = (st != S_IDLE);
    assign done     = (st == S_FIN);
    assign fault    = (st == S_ERR);
    assign rf_we    = done && wb_en;
    assign rf_waddr = wb_addr;
    assign rf_wdata = wb_val;
    assign operand  = opnd_q;
    assign ea       = ea_q;

    // R11: completion is a single-cycle event
    p_single_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        (done || fault) |=> !(done || fault));

    // R10: an errored acknowledge is followed by fault
    p_err_to_fault_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && mem_ack && mem_err) |=> fault);

endmodule

// File: rtl/ofs_operand_seq.sv
module ofs_operand_seq
    import ofs_pkg::*;
#(
    parameter int unsigned DW     = 16,
    parameter int unsigned NREG   = 8,
    parameter int unsigned SP_IDX = 6,
    parameter int unsigned PC_IDX = 7
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [MODE_W-1:0]       mode,
    input  logic [$clog2(NREG)-1:0] reg_sel,
    input  logic [KIND_W-1:0]       kind,
    input  logic                    byte_op,
    input  logic [DW-1:0]           wr_data,
    output logic                    busy,
    output logic                    done,
    output logic                    fault,
    output logic [DW-1:0]           operand,
    output logic [DW-1:0]           ea,
    output logic [$clog2(NREG)-1:0] rf_raddr,
    input  logic [DW-1:0]           rf_rdata,
    output logic                    rf_we,
    output logic [$clog2(NREG)-1:0] rf_waddr,
    output logic [DW-1:0]           rf_wdata,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic                    mem_byte,
    output logic [DW-1:0]           mem_addr,
    output logic [DW-1:0]           mem_wdata,
    input  logic [DW-1:0]           mem_rdata,
    input  logic                    mem_ack,
    input  logic                    mem_err
);
    localparam int unsigned RW = $clog2(NREG);

    logic [DW-1:0] base_q, inc_val, dec_val, go_addr, go_wdata;
    logic [RW-1:0] rsel_q;
    cmd_t          cmd_q;
    logic          go, go_we, go_byte;

    ofs_step_calc #(.DW(DW), .RW(RW), .SP_IDX(SP_IDX), .PC_IDX(PC_IDX)) u_step (
        .base    (base_q),
        .rsel    (rsel_q),
        .mode    (cmd_q.mode),
        .byte_op (cmd_q.byte_op),
        .inc_val (inc_val),
        .dec_val (dec_val)
    );

    ofs_ctrl #(.DW(DW), .RW(RW), .PC_IDX(PC_IDX)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mode_i    (mode_e'(mode)),
        .reg_sel   (reg_sel),
        .kind_i    (kind_e'(kind)),
        .byte_op   (byte_op),
        .wr_data   (wr_data),
        .rf_rdata  (rf_rdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .mem_err   (mem_err),
        .inc_val   (inc_val),
        .dec_val   (dec_val),
        .base_q    (base_q),
        .rsel_q    (rsel_q),
        .cmd_q     (cmd_q),
        .rf_raddr  (rf_raddr),
        .go        (go),
        .go_addr   (go_addr),
        .go_we     (go_we),
        .go_byte   (go_byte),
        .go_wdata  (go_wdata),
        .busy      (busy),
        .done      (done),
        .fault     (fault),
        .rf_we     (rf_we),
        .rf_waddr  (rf_waddr),
        .rf_wdata  (rf_wdata),
        .operand   (operand),
        .ea        (ea)
    );

    ofs_memport #(.DW(DW)) u_mem (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .go_addr   (go_addr),
        .go_we     (go_we),
        .go_byte   (go_byte),
        .go_wdata  (go_wdata),
        .mem_ack   (mem_ack),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_byte  (mem_byte),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    // R1: nothing leaves the block while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !rf_we));

    // R10: a failed sequence releases memory and writes no register
    p_fault_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        fault |-> (!mem_req && !rf_we));

    // R11: register update only in a done cycle
    p_wb_in_done_r11: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (done && !fault));

endmodule

// File: tb/tb_ofs_operand_seq.sv
module tb_ofs_operand_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [2:0]  reg_sel = '0;
    logic [1:0]  kind = '0;
    logic        byte_op = 1'b0;
    logic [15:0] wr_data = '0;
    logic        busy, done, fault;
    logic [15:0] operand, ea;
    logic [2:0]  rf_raddr, rf_waddr;
    logic [15:0] rf_rdata, rf_wdata;
    logic        rf_we;
    logic        mem_req, mem_we, mem_byte;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;

    always #5 clk = ~clk;

    ofs_operand_seq dut (.*);

    int n_checks = 0;
    int n_errors = 0;

    // register file model
    logic [15:0] regs [8];
    logic [15:0] init_regs [8];
    logic        load_regs = 1'b0;
    assign rf_rdata = regs[rf_raddr];

    always @(posedge clk) begin
        if (load_regs) begin
            for (int k = 0; k < 8; k++) regs[k] <= init_regs[k];
        end else if (rf_we) begin
            regs[rf_waddr] <= rf_wdata;
        end
    end

    function automatic logic [15:0] memf(input logic [15:0] a);
        return {a[6:0], a[15:7]} ^ 16'h3C5A;
    endfunction

    // memory responder with random waits and error injection
    int          acc_no = 0;
    int          err_at = 99;
    int          wait_n = 1;
    int          wait_cnt = 0;
    logic [15:0] lg_addr [8];
    logic [15:0] lg_wdata [8];
    logic        lg_we [8];
    logic        lg_byte [8];

    always @(posedge clk) begin
        if (rst || load_regs) begin
            acc_no   <= 0;
            mem_ack  <= 1'b0;
            mem_err  <= 1'b0;
            wait_cnt <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
        end else if (mem_req) begin
            if (wait_cnt >= wait_n) begin
                mem_ack   <= 1'b1;
                mem_rdata <= memf(mem_addr);
                mem_err   <= (acc_no == err_at);
                if (acc_no < 8) begin
                    lg_addr[acc_no[2:0]]  <= mem_addr;
                    lg_wdata[acc_no[2:0]] <= mem_wdata;
                    lg_we[acc_no[2:0]]    <= mem_we;
                    lg_byte[acc_no[2:0]]  <= mem_byte;
                end
                acc_no   <= acc_no + 1;
                wait_cnt <= 0;
                wait_n   <= $urandom_range(0, 3);
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string mode_tag(input int m);
        case (m)
            0: return "R2";
            1: return "R3";
            2, 3: return "R4";
            4, 5: return "R5";
            default: return "R6";
        endcase
    endfunction

    // expected access list
    logic [15:0] e_addr [8];
    logic [15:0] e_wdata [8];
    logic        e_we [8];
    logic        e_byte [8];
    int          e_n;

    task automatic push(input logic [15:0] a, input bit we, input bit b, input logic [15:0] d);
        e_addr[e_n]  = a;
        e_we[e_n]    = we;
        e_byte[e_n]  = b;
        e_wdata[e_n] = d;
        e_n++;
    endtask

    task automatic run_txn(input int m, input int r, input int k, input bit b,
                           input logic [15:0] wd, input int eat, input string tag);
        logic [15:0] xr [8];
        logic [15:0] base, stp, p, pc, np, xea, xop;
        bit          xfault, got_d, got_f, regs_ok, list_ok;
        logic [15:0] gop, gea;
        int          cyc;
        string       t, ft;

        for (int i = 0; i < 8; i++) begin
            init_regs[i] = 16'($urandom);
            xr[i] = init_regs[i];
        end
        base   = init_regs[r];
        stp    = (b && (m == 2 || m == 4) && r < 6) ? 16'd1 : 16'd2;   // R7
        e_n    = 0;
        xfault = 0;
        xea    = 0;
        xop    = 0;
        case (m)
            0: begin
                if (k == 2) xfault = 1;
                else if (k == 1) xr[r] = wd;
                else xop = base;
            end
            1: xea = base;
            2: begin xea = base; xr[r] = base + stp; end
            3: begin push(base, 0, 0, wd); xea = memf(base); xr[r] = base + 16'd2; end
            4: begin xea = base - stp; xr[r] = xea; end
            5: begin p = base - 16'd2; push(p, 0, 0, wd); xea = memf(p); xr[r] = p; end
            default: begin
                pc = init_regs[7];
                push(pc, 0, 0, wd);
                np = pc + 16'd2;
                xea = memf(pc) + ((r == 7) ? np : base);
                xr[7] = np;
                if (m == 7) begin push(xea, 0, 0, wd); xea = memf(xea); end
            end
        endcase
        if (m != 0) begin
            if (k == 1) push(xea, 1, b, wd);
            else if (k != 2) begin push(xea, 0, b, wd); xop = memf(xea); end
        end
        if (eat < e_n) begin
            xfault = 1;
            e_n = eat + 1;
            for (int i = 0; i < 8; i++) xr[i] = init_regs[i];
        end

        t  = (tag.len() != 0) ? tag : mode_tag(m);
        ft = (xfault && m != 0) ? "R10" : t;

        @(negedge clk);
        load_regs = 1'b1;
        err_at    = eat;
        @(negedge clk);
        load_regs = 1'b0;
        start     = 1'b1;
        mode      = 3'(m);
        reg_sel   = 3'(r);
        kind      = 2'(k);
        byte_op   = b;
        wr_data   = wd;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!(done || fault) && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        got_d = done;
        got_f = fault;
        gop   = operand;
        gea   = ea;
        chk(cyc < 200, ft, "completion before timeout", 32'(cyc), 32'd200);
        chk(got_d == !xfault && got_f == xfault, ft, "outcome {done,fault}",
            {30'd0, got_d, got_f}, {30'd0, !xfault, xfault});
        if (!xfault && (k == 0 || k == 3)) chk(gop == xop, t, "operand", 32'(gop), 32'(xop));
        if (!xfault) chk(gea == xea, (m == 0) ? "R2" : t, "effective address", 32'(gea), 32'(xea));
        @(negedge clk);
        chk(!done && !fault, "R11", "single completion pulse", {30'd0, done, fault}, 32'd0);
        regs_ok = 1;
        for (int i = 0; i < 8; i++) if (regs[i] !== xr[i]) regs_ok = 0;
        chk(regs_ok, ft, $sformatf("register file (R%0d)", r), 32'(regs[r]), 32'(xr[r]));
        chk(acc_no == e_n, (m == 0) ? "R2" : "R8", "access count", 32'(acc_no), 32'(e_n));
        list_ok = 1;
        for (int i = 0; i < e_n && i < 8; i++) begin
            if (lg_addr[i] !== e_addr[i] || lg_we[i] !== e_we[i] || lg_byte[i] !== e_byte[i]
                || (e_we[i] && lg_wdata[i] !== e_wdata[i])) list_ok = 0;
        end
        chk(list_ok, "R9", "access address/type list", 32'(lg_addr[0]), 32'(e_addr[0]));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd5150));
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !fault && !mem_req && !rf_we, "R1", "reset idle outputs",
            {27'd0, busy, done, fault, mem_req, rf_we}, 32'd0);

        // every mode x register x flow, no errors
        for (int m = 0; m < 8; m++)
            for (int r = 0; r < 8; r++)
                for (int k = 0; k < 3; k++)
                    run_txn(m, r, k, 1'($urandom_range(0, 1)), 16'($urandom), 99, "");

        // step size corners (R7)
        run_txn(2, 3, 0, 1'b1, 16'h0, 99, "R7");
        run_txn(4, 0, 2, 1'b1, 16'h0, 99, "R7");
        run_txn(2, 6, 0, 1'b1, 16'h0, 99, "R7");
        run_txn(4, 7, 2, 1'b1, 16'h0, 99, "R7");
        run_txn(3, 1, 0, 1'b1, 16'h0, 99, "R7");
        run_txn(5, 2, 1, 1'b1, 16'hBEEF, 99, "R7");
        // reserved kind behaves as read (R8)
        run_txn(6, 2, 3, 1'b0, 16'h0, 99, "R8");
        // error at each access of deepest flows (R10)
        for (int e = 0; e < 3; e++) run_txn(7, 7, 0, 1'b0, 16'h0, e, "R10");
        for (int e = 0; e < 2; e++) run_txn(5, 4, 1, 1'b0, 16'h1234, e, "R10");
        run_txn(2, 6, 1, 1'b0, 16'h55AA, 0, "R10");

        // random mix with injected errors
        for (int n = 0; n < 150; n++) begin
            run_txn($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 2),
                    1'($urandom_range(0, 1)), 16'($urandom),
                    ($urandom_range(0, 1) == 1) ? $urandom_range(0, 3) : 99, "");
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule